// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every event that can restart the chip into a single active-high system reset, `sys_rst`, and decides the cycle in which that reset lets go. The events are: power-on, the external active-low reset pin (seen while running and while sleeping), a watchdog timeout while running, brown-out, a software reset instruction, a trap lock-up, and an illegal-opcode or bad-pointer fault. The external pin is only ever read. Internal causes never drive it. Its level passes through a two-stage synchronizer and a debounce counter, so short glitches are ignored.

After power-on or brown-out, the reset is held through a fixed bias-settling delay and then a selectable power-up delay. Other causes hold the reset only while they are active. In every case the release waits for a cycle in which the phase marker `q1_mark` is high. A watchdog timeout during sleep counts as a wake-up, not a reset: it raises `wdt_wake` for one cycle and changes nothing else. Each cause sets its own sticky bit in `cause_flags`. Software clears a bit by writing zero to it.

The sequencer runs as a five-state machine:
- `ST_BIAS` counts the bias delay.
- `ST_PWRT` counts the power-up delay.
- `ST_HOLD` waits while a level or pulse cause is active.
- `ST_ALIGN` waits for the phase marker.
- `ST_RUN` has the reset released.

The transitions are:
- Brown-out from any state goes to `ST_BIAS`.
- Bias done goes to `ST_PWRT`, or straight to `ST_ALIGN` when the selected delay is zero.
- Power-up done goes to `ST_ALIGN`.
- An active cause moves `ST_ALIGN` or `ST_RUN` to `ST_HOLD`.
- Cause gone moves `ST_HOLD` to `ST_ALIGN`.
- Marker seen with no cause moves `ST_ALIGN` to `ST_RUN`.

Power-on (`por_req`) re-initialises everything into `ST_BIAS`.

Top module: `reset_sequencer`

## Requirements
- R1: In the cycle after `por_req` is high, `sys_rst` is 1 and `cause_flags` reads 0x01: bit 0 (power-on) is set and all other bits are cleared.
- R2: After `por_req` falls, the reset is held for BIAS_CYC cycles, then for a power-up delay selected by `pwrt_sel`. The codes 0, 1, 2 and 3 select 0, 4×UNIT_CYC, 16×UNIT_CYC and 64×UNIT_CYC cycles. With `q1_mark` held high, `sys_rst` falls after exactly BIAS_CYC + delay + 1 clock edges.
- R3: `sys_rst` falls only at an edge where `q1_mark` is 1. Without the marker the reset stays asserted indefinitely.
- R4: A low pulse on `pin_n` that lasts fewer than FILT_LEN consecutive sampled cycles has no effect. A low level of FILT_LEN or more cycles asserts `sys_rst` FILT_LEN+3 edges after it starts. Once the pin returns high, `sys_rst` falls FILT_LEN+4 edges later.
- R5: A filtered pin reset sets bit 1 when `sleeping` is 0 and bit 2 when `sleeping` is 1.
- R6: `wdt_expire` with `sleeping` = 0 asserts the reset and sets bit 3. With `sleeping` = 1 it leaves `sys_rst` and `cause_flags` unchanged and pulses `wdt_wake` high on the next cycle.
- R7: `bor_req` sets bit 4 and holds the reset. When it falls, the full delay chain of R2 restarts.
- R8: A one-cycle pulse on `sw_rst`, `trap_lock` or `bad_op` sets bit 5, 6 or 7 respectively. It asserts `sys_rst` for three edges when `q1_mark` is high.
- R9: Flags are sticky. While `flag_wr_en` is 1, each bit written 0 is cleared and each bit written 1 is kept. A cause that is active in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_req | input | 1 | Power-on indication, active high; initialises the block |
| pin_n | input | 1 | External reset pin, active low, never driven |
| sleeping | input | 1 | Core is in sleep |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| bor_req | input | 1 | Brown-out detected, level |
| sw_rst | input | 1 | Software reset instruction pulse |
| trap_lock | input | 1 | Trap conflict lock-up pulse |
| bad_op | input | 1 | Illegal opcode or bad pointer pulse |
| pwrt_sel | input | 2 | Power-up delay select |
| q1_mark | input | 1 | Phase-1 marker |
| flag_wr_en | input | 1 | Cause flag write strobe |
| flag_wr_data | input | 8 | Cause flag write data; a 0 clears that bit |
| sys_rst | output | 1 | System reset, active high |
| wdt_wake | output | 1 | One-cycle wake pulse from a watchdog timeout during sleep |
| cause_flags | output | 8 | Sticky reset cause flags |

## Verification
The release timing is swept over all four delay codes, both after power-on and after brown-out. Because the expected edge counts differ for every code, a wrong count or a lost bias stage shows up as a distinct number. The pin filter is driven with low pulses of every width from one cycle up to FILT_LEN+2, both awake and asleep. This separates an off-by-one in the debounce threshold and confirms that the sleep input steers the pin cause to the correct flag.

Each single-cycle cause is fired alone, and the bench checks both its flag bit and the exact release edge. The watchdog is fired twice: once awake, where it must reset, and once asleep, where it must only wake. Withholding the phase marker, and clearing flags while a cause fires in the same cycle, exercise the alignment and the set-over-clear priority.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_BIAS,
        ST_PWRT,
        ST_HOLD,
        ST_ALIGN,
        ST_RUN
    } seq_state_t;

    localparam int unsigned NUM_CAUSES = 8;

    // flag bit positions
    localparam int unsigned CF_POR     = 0;
    localparam int unsigned CF_PIN_RUN = 1;
    localparam int unsigned CF_PIN_SLP = 2;
    localparam int unsigned CF_WDT     = 3;
    localparam int unsigned CF_BOR     = 4;
    localparam int unsigned CF_SWR     = 5;
    localparam int unsigned CF_TRAP    = 6;
    localparam int unsigned CF_BADOP   = 7;

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic init,
    input  logic pin_n,
    output logic asserted
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;
    logic          asserted_q;
    logic          low_now;

    assign low_now = ~sync_q[1];

    always_ff @(posedge clk) begin
        if (init) begin
            sync_q     <= 2'b11;
            run_cnt    <= '0;
            asserted_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_n};
            if (low_now != asserted_q) begin
                if (run_cnt == CW'(FILT_LEN - 1)) begin
                    asserted_q <= low_now;
                    run_cnt    <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign asserted = asserted_q;

endmodule

// File: rtl/rstseq_cause_reg.sv
module rstseq_cause_reg
    import rstseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  init,
    input  logic [NUM_CAUSES-1:0] set_vec,
    input  logic                  wr_en,
    input  logic [NUM_CAUSES-1:0] wr_data,
    output logic [NUM_CAUSES-1:0] flags
);
    logic [NUM_CAUSES-1:0] flag_q;

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (init) begin
                flag_q[i] <= (i == CF_POR);
            end else if (set_vec[i]) begin
                flag_q[i] <= 1'b1;
            end else if (wr_en && !wr_data[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned BIAS_CYC = 5,
    parameter int unsigned UNIT_CYC = 3
) (
    input  logic       clk,
    input  logic       init,
    input  logic       restart,
    input  logic       hold_req,
    input  logic       q1_mark,
    input  logic [1:0] pwrt_sel,
    output logic       sys_rst
);
    localparam int unsigned LEN4  = 4  * UNIT_CYC;
    localparam int unsigned LEN16 = 16 * UNIT_CYC;
    localparam int unsigned LEN64 = 64 * UNIT_CYC;
    localparam int unsigned MAXC  = (BIAS_CYC > LEN64) ? BIAS_CYC : LEN64;
    localparam int unsigned CW    = $clog2(MAXC + 1);

    seq_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] pwrt_len;

    always_comb begin
        unique case (pwrt_sel)
            2'd0:    pwrt_len = '0;
            2'd1:    pwrt_len = CW'(LEN4);
            2'd2:    pwrt_len = CW'(LEN16);
            default: pwrt_len = CW'(LEN64);
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (init) begin
            st_q  <= ST_BIAS;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (restart) begin
            st_d  = ST_BIAS;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_BIAS: begin
                    if (cnt_q == CW'(BIAS_CYC - 1)) begin
                        cnt_d = '0;
                        st_d  = (pwrt_len == '0) ? ST_ALIGN : ST_PWRT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PWRT: begin
                    if (cnt_q == pwrt_len - 1'b1) begin
                        cnt_d = '0;
                        st_d  = ST_ALIGN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!hold_req) st_d = ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (hold_req)     st_d = ST_HOLD;
                    else if (q1_mark) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (hold_req) st_d = ST_HOLD;
                end
                default: begin
                    st_d  = ST_BIAS;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_RUN:  sys_rst = 1'b0;
            default: sys_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned BIAS_CYC = 5,
    parameter int unsigned UNIT_CYC = 3,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       por_req,
    input  logic       pin_n,
    input  logic       sleeping,
    input  logic       wdt_expire,
    input  logic       bor_req,
    input  logic       sw_rst,
    input  logic       trap_lock,
    input  logic       bad_op,
    input  logic [1:0] pwrt_sel,
    input  logic       q1_mark,
    input  logic       flag_wr_en,
    input  logic [7:0] flag_wr_data,
    output logic       sys_rst,
    output logic       wdt_wake,
    output logic [7:0] cause_flags
);
    logic                  pin_asserted;
    logic                  wdt_run;
    logic                  hold_req;
    logic [NUM_CAUSES-1:0] set_vec;
    logic                  wake_q;

    rstseq_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .init     (por_req),
        .pin_n    (pin_n),
        .asserted (pin_asserted)
    );

    assign wdt_run  = wdt_expire & ~sleeping;
    assign hold_req = pin_asserted | wdt_run | sw_rst | trap_lock | bad_op;

    always_comb begin
        set_vec             = '0;
        set_vec[CF_PIN_RUN] = pin_asserted & ~sleeping;
        set_vec[CF_PIN_SLP] = pin_asserted & sleeping;
        set_vec[CF_WDT]     = wdt_run;
        set_vec[CF_BOR]     = bor_req;
        set_vec[CF_SWR]     = sw_rst;
        set_vec[CF_TRAP]    = trap_lock;
        set_vec[CF_BADOP]   = bad_op;
    end

    rstseq_cause_reg u_flags (
        .clk     (clk),
        .init    (por_req),
        .set_vec (set_vec),
        .wr_en   (flag_wr_en),
        .wr_data (flag_wr_data),
        .flags   (cause_flags)
    );

    rstseq_fsm #(.BIAS_CYC(BIAS_CYC), .UNIT_CYC(UNIT_CYC)) u_fsm (
        .clk      (clk),
        .init     (por_req),
        .restart  (bor_req),
        .hold_req (hold_req),
        .q1_mark  (q1_mark),
        .pwrt_sel (pwrt_sel),
        .sys_rst  (sys_rst)
    );

    always_ff @(posedge clk) begin
        if (por_req) wake_q <= 1'b0;
        else         wake_q <= wdt_expire & sleeping;
    end

    assign wdt_wake = wake_q;

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
    input logic       clk,
    input logic       por_req,
    input logic       sleeping,
    input logic       wdt_expire,
    input logic       bor_req,
    input logic       sw_rst,
    input logic       trap_lock,
    input logic       bad_op,
    input logic       q1_mark,
    input logic       flag_wr_en,
    input logic       sys_rst,
    input logic       wdt_wake,
    input logic [7:0] cause_flags,
    input logic       pin_asserted
);
    a_r1_por_flags: assert property (@(posedge clk) disable iff (por_req)
        $past(por_req) |-> (cause_flags == 8'h01 && sys_rst));

    a_r3_release_on_q1: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> $past(q1_mark));

    a_r6_wake_no_reset: assert property (@(posedge clk) disable iff (por_req)
        (!sys_rst && wdt_expire && sleeping && !pin_asserted && !bor_req &&
         !sw_rst && !trap_lock && !bad_op) |=> (!sys_rst && wdt_wake));

    a_r7_bor_holds: assert property (@(posedge clk) disable iff (por_req)
        bor_req |=> (sys_rst && cause_flags[4]));

    a_r8_sw_flag: assert property (@(posedge clk) disable iff (por_req)
        sw_rst |=> (sys_rst && cause_flags[5]));

    a_r9_sticky: assert property (@(posedge clk) disable iff (por_req)
        !flag_wr_en |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

endmodule

bind reset_sequencer rstseq_checker u_chk (
    .clk          (clk),
    .por_req      (por_req),
    .sleeping     (sleeping),
    .wdt_expire   (wdt_expire),
    .bor_req      (bor_req),
    .sw_rst       (sw_rst),
    .trap_lock    (trap_lock),
    .bad_op       (bad_op),
    .q1_mark      (q1_mark),
    .flag_wr_en   (flag_wr_en),
    .sys_rst      (sys_rst),
    .wdt_wake     (wdt_wake),
    .cause_flags  (cause_flags),
    .pin_asserted (pin_asserted)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
    localparam int BIAS = 5;
    localparam int UNIT = 3;
    localparam int FL   = 4;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       pin_n = 1'b1;
    logic       sleeping = 1'b0;
    logic       wdt_expire = 1'b0;
    logic       bor_req = 1'b0;
    logic       sw_rst = 1'b0;
    logic       trap_lock = 1'b0;
    logic       bad_op = 1'b0;
    logic [1:0] pwrt_sel = 2'd0;
    logic       q1_mark = 1'b1;
    logic       flag_wr_en = 1'b0;
    logic [7:0] flag_wr_data = 8'h00;
    logic       sys_rst;
    logic       wdt_wake;
    logic [7:0] cause_flags;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_flags;

    always #5 clk = ~clk;

    reset_sequencer #(.BIAS_CYC(BIAS), .UNIT_CYC(UNIT), .FILT_LEN(FL)) u_reset_sequencer (
        .clk(clk), .por_req(por_req), .pin_n(pin_n), .sleeping(sleeping),
        .wdt_expire(wdt_expire), .bor_req(bor_req), .sw_rst(sw_rst),
        .trap_lock(trap_lock), .bad_op(bad_op), .pwrt_sel(pwrt_sel),
        .q1_mark(q1_mark), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .sys_rst(sys_rst), .wdt_wake(wdt_wake), .cause_flags(cause_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int plen(input int s);
        case (s)
            0: return 0;
            1: return 4 * UNIT;
            2: return 16 * UNIT;
            default: return 64 * UNIT;
        endcase
    endfunction

    // edges until sys_rst equals val, counted from the current negedge
    task automatic edges_until(input logic val, output int n);
        n = 0;
        while (sys_rst !== val && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_flags(input logic [7:0] d);
        flag_wr_en = 1'b1; flag_wr_data = d;
        @(negedge clk);
        flag_wr_en = 1'b0;
    endtask

    task automatic pulse_cause(input int which);
        case (which)
            0: sw_rst = 1'b1;
            1: trap_lock = 1'b1;
            2: bad_op = 1'b1;
            default: wdt_expire = 1'b1;
        endcase
        @(negedge clk);
        sw_rst = 1'b0; trap_lock = 1'b0; bad_op = 1'b0; wdt_expire = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset level", sys_rst, 1);
        chk("R1 flags", cause_flags, 8'h01);

        // R2: delay chain for all codes
        for (int s = 0; s < 4; s++) begin
            por_req = 1'b1; pwrt_sel = 2'(s);
            repeat (2) @(negedge clk);
            por_req = 1'b0;
            edges_until(1'b0, n);
            chk($sformatf("R2 release edges sel=%0d", s), n, BIAS + plen(s) + 1);
            chk("R1 flags after por", cause_flags, 8'h01);
        end

        // R3: no marker, no release
        por_req = 1'b1; pwrt_sel = 2'd0; q1_mark = 1'b0;
        repeat (2) @(negedge clk);
        por_req = 1'b0;
        repeat (BIAS + 20) @(negedge clk);
        chk("R3 held without marker", sys_rst, 1);
        q1_mark = 1'b1;
        @(negedge clk);
        chk("R3 released on marker", sys_rst, 0);
        exp_flags = 8'h01;

        // R8 / R6: single-cycle causes
        for (int c = 0; c < 4; c++) begin
            pulse_cause(c);
            exp_flags |= (c == 0) ? 8'h20 : (c == 1) ? 8'h40 : (c == 2) ? 8'h80 : 8'h08;
            chk($sformatf("R8 R6 asserted cause=%0d", c), sys_rst, 1);
            chk($sformatf("R8 R6 flag cause=%0d", c), cause_flags, exp_flags);
            edges_until(1'b0, n);
            chk($sformatf("R8 release cause=%0d", c), n, 2);
        end

        // R6: watchdog while asleep
        sleeping = 1'b1;
        pulse_cause(3);
        chk("R6 sleep no reset", sys_rst, 0);
        chk("R6 sleep wake pulse", wdt_wake, 1);
        chk("R6 sleep flags unchanged", cause_flags, exp_flags);
        @(negedge clk);
        chk("R6 wake one cycle", wdt_wake, 0);
        sleeping = 1'b0;

        // R9: write zero clears, one keeps
        clear_flags(~8'h20);
        exp_flags &= ~8'h20;
        chk("R9 selective clear", cause_flags, exp_flags);
        sw_rst = 1'b1; flag_wr_en = 1'b1; flag_wr_data = 8'h00;
        @(negedge clk);
        sw_rst = 1'b0; flag_wr_en = 1'b0;
        chk("R9 set wins over clear", cause_flags, 8'h20);
        edges_until(1'b0, n);
        clear_flags(8'h00);
        chk("R9 all cleared", cause_flags, 8'h00);

        // R7: brown-out restarts the chain
        for (int s = 0; s < 4; s++) begin
            pwrt_sel = 2'(s);
            bor_req = 1'b1;
            repeat (3) @(negedge clk);
            chk("R7 held in brown-out", sys_rst, 1);
            bor_req = 1'b0;
            edges_until(1'b0, n);
            chk($sformatf("R7 release edges sel=%0d", s), n, BIAS + plen(s) + 1);
            chk("R7 flag", cause_flags, 8'h10);
            clear_flags(8'h00);
        end
        pwrt_sel = 2'd0;

        // R4: pin assertion and release timing
        pin_n = 1'b0;
        edges_until(1'b1, n);
        chk("R4 assert edges", n, FL + 3);
        pin_n = 1'b1;
        edges_until(1'b0, n);
        chk("R4 release edges", n, FL + 4);
        chk("R5 run flag", cause_flags, 8'h02);
        clear_flags(8'h00);

        // R4 / R5: pulse-width sweep awake and asleep
        for (int sl = 0; sl < 2; sl++) begin
            sleeping = sl[0];
            for (int w = 1; w <= FL + 2; w++) begin
                pin_n = 1'b0;
                repeat (w) @(negedge clk);
                pin_n = 1'b1;
                repeat (FL + 12) @(negedge clk);
                chk($sformatf("R4 R5 flag w=%0d sleep=%0d", w, sl), cause_flags,
                    (w >= FL) ? (sl ? 8'h04 : 8'h02) : 8'h00);
                chk($sformatf("R4 no lingering reset w=%0d", w), sys_rst, 0);
                clear_flags(8'h00);
            end
        end
        sleeping = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule